// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for Ethernet PHYs. It drives a management clock (MDC) and a bidirectional data line (MDIO), and it can produce either the Clause 22 or the Clause 45 frame format. Software controls it through four 32-bit registers on a simple word-addressed host port. One register holds configuration and status, one holds the target addresses, one holds data and one holds the register address. The MDIO line is presented as a separate output value, output enable and input, so that a pad cell can build the tristate.

A transaction starts as a side effect of a host write:

- Writing the data word launches a write frame.
- Writing the control word with its read bit set launches a read frame.
- In Clause 45 mode, writing the address word launches an address frame.

MDC is derived from the system clock by a programmable divisor. The 32-bit preamble of ones can be switched off. While a frame is on the wire the busy flag is set and the register file does not accept host writes. When a read finishes, the 16 captured bits replace the data word. If no PHY answered the turnaround, the error flag is set.

Top module: `mdio_master`

## Requirements
- R1: The registers sit at word addresses 12 (configuration/status), 13 (control), 14 (data) and 15 (address). Every other word reads as zero. After reset:
  - configuration/status reads 0x280 (divisor 5, everything else clear);
  - all other registers read zero;
  - MDC is high and MDIO is released.
- R2: While a frame runs, each MDC half period is divisor+1 system clocks, so a full period is 2×(divisor+1). The divisor sits in configuration bits 15:7, and values 5 to 511 work. Between frames MDC rests high and MDIO is released (`mdio_oe` low).
- R3: A host write to the data word (bits 15:0) with the Clause 45 bit (configuration bit 6) clear sends a Clause 22 write frame. The frame is start 01, opcode 01, 5-bit port (control bits 9:5), 5-bit register (control bits 4:0), turnaround 10, then the 16 data bits, all sent MSB first.
- R4: A host write to the control word with bit 15 set starts a read frame. It uses the port and device fields carried in that same write.
  - In Clause 22 the opcode is 10.
  - From the first turnaround bit onward, the master releases MDIO.
  - The 16 sampled data bits become the new data word.
  - Control bit 15 always reads back as zero.
- R5: With the Clause 45 bit set, a host write to the address word sends start 00, opcode 00, port, device, turnaround 10 and the 16-bit register address. With the Clause 45 bit clear, the same write only stores the value and starts no frame.
- R6: In Clause 45 mode, write frames carry start 00 and opcode 01, and read frames carry start 00 and opcode 11.
- R7: With configuration bit 5 clear, every frame is preceded by 32 ones. With it set, the frame begins directly with the start bits.
- R8: Configuration bit 0 reads 1 from the cycle after a frame-starting write until the frame's last rising MDC edge. While it is set, every host write is ignored. Ignored writes change neither the registers nor the frame on the wire.
- R9: Configuration bit 1 is set when the second turnaround bit of a read is sampled high, which means no PHY pulled the line low. It is cleared when the next read starts. With a pulled-up line and no PHY, the data word reads 0xFFFF.
- R10: The master changes MDIO value and enable only right after a falling MDC edge, and it samples MDIO on rising MDC edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | BUS_AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for `host_addr` (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output enable, high while the master drives |
| mdio_in | input | 1 | MDIO line as seen at the pad |

## Verification
The bench stands in for a PHY with a pulled-up line. It logs every bit present at each rising MDC edge, together with whether the master was driving it. Each frame is then compared bit by bit with a frame the bench composes itself.

A wrong index or opcode in the shifter shows up within the same frame as a mismatching wire pattern or bit count. A wrong capture window shows up as a wrong data word or error flag as soon as busy falls. A divider fault is measured directly as the spacing between falling MDC edges. A busy-gating fault shows up in the next frame or in the very next register read.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   localparam int PRE_BITS   = 32;
   localparam int FRAME_BITS = 32;
   localparam int DATA_BITS  = 16;
   localparam int FLD_BITS   = 5;

   // host word addresses
   localparam int OFS_CFG  = 12;
   localparam int OFS_CTRL = 13;
   localparam int OFS_DATA = 14;
   localparam int OFS_ADDR = 15;

   // bit positions used by the register file
   localparam int CTRL_RD_BIT = 15;
   localparam int CFG_PRE_BIT = 5;
   localparam int CFG_C45_BIT = 6;
   localparam int CFG_DIV_LO  = 7;

   typedef enum logic [1:0] {
      FR_ADDR  = 2'd0,
      FR_WRITE = 2'd1,
      FR_READ  = 2'd2
   } fr_kind_e;

   function automatic logic [FRAME_BITS-1:0] make_frame(
      input logic                 c45,
      input fr_kind_e             kind,
      input logic [FLD_BITS-1:0]  prt,
      input logic [FLD_BITS-1:0]  dev,
      input logic [DATA_BITS-1:0] dat
   );
      logic [1:0] st, op, ta;
      st = c45 ? 2'b00 : 2'b01;
      ta = (kind == FR_READ) ? 2'b11 : 2'b10;
      unique case (kind)
         FR_ADDR:  op = 2'b00;
         FR_WRITE: op = 2'b01;
         default:  op = c45 ? 2'b11 : 2'b10;
      endcase
      return {st, op, prt, dev, ta, dat};
   endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_W = 9
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             fall_stb,
   output logic             rise_stb
);

   logic [DIV_W-1:0] cnt_q;
   logic             wrap;

   assign wrap     = run && (cnt_q == div);
   assign fall_stb = wrap && mdc;
   assign rise_stb = wrap && !mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b1;
      end else if (!run) begin
         cnt_q <= '0;
         mdc   <= 1'b1;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc   <= ~mdc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
   import mdio_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  is_read,
   input  logic                  skip_pre,
   input  logic [FRAME_BITS-1:0] frame,
   input  logic                  fall_stb,
   input  logic                  rise_stb,
   input  logic                  line_in,
   output logic                  busy,
   output logic                  mdio_out,
   output logic                  mdio_oe,
   output logic                  rd_done,
   output logic                  rd_err,
   output logic [DATA_BITS-1:0]  rd_word
);

   localparam int TOTAL = PRE_BITS + FRAME_BITS;
   localparam int IDX_W = $clog2(TOTAL);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
   localparam logic [IDX_W-1:0] FIRST_FR = IDX_W'(PRE_BITS);
   localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(PRE_BITS + 14);
   localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PRE_BITS + 15);
   localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_BITS + 16);

   logic [TOTAL-1:0]     word_q;
   logic [IDX_W-1:0]     nxt_q, cur_q;
   logic                 read_q;
   logic                 err_q;
   logic [DATA_BITS-1:0] sh_q;
   logic                 last_rise;

   assign last_rise = busy && rise_stb && (cur_q == LAST_IDX);
   assign rd_done   = last_rise && read_q;
   assign rd_word   = {sh_q[DATA_BITS-2:0], line_in};
   assign rd_err    = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         word_q   <= '1;
         nxt_q    <= '0;
         cur_q    <= '0;
         read_q   <= 1'b0;
         err_q    <= 1'b0;
         sh_q     <= '0;
         mdio_out <= 1'b1;
         mdio_oe  <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            word_q <= {{PRE_BITS{1'b1}}, frame};
            nxt_q  <= skip_pre ? FIRST_FR : '0;
            read_q <= is_read;
            if (is_read) err_q <= 1'b0;
         end
      end else begin
         if (fall_stb) begin
            mdio_out <= word_q[LAST_IDX - nxt_q];
            mdio_oe  <= !(read_q && (nxt_q >= TA1_IDX));
            cur_q    <= nxt_q;
            nxt_q    <= nxt_q + 1'b1;
         end
         if (rise_stb) begin
            if (read_q && cur_q == TA2_IDX) err_q <= line_in;
            if (read_q && cur_q >= DAT_IDX) sh_q <= rd_word;
            if (cur_q == LAST_IDX) begin
               busy    <= 1'b0;
               mdio_oe <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile
   import mdio_pkg::*;
#(
   parameter int DIV_W   = 9,
   parameter int DIV_RST = 5,
   parameter int BUS_AW  = 4
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  host_wr,
   input  logic [BUS_AW-1:0]     host_addr,
   input  logic [31:0]           host_wdata,
   output logic [31:0]           host_rdata,
   input  logic                  busy,
   input  logic                  rd_err,
   input  logic                  rd_done,
   input  logic [DATA_BITS-1:0]  rd_word,
   output logic                  start,
   output logic                  start_read,
   output logic [FRAME_BITS-1:0] frame,
   output logic [DIV_W-1:0]      cfg_div,
   output logic                  cfg_pre_off,
   output logic                  cfg_c45
);

   localparam logic [BUS_AW-1:0] A_CFG  = BUS_AW'(OFS_CFG);
   localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(OFS_CTRL);
   localparam logic [BUS_AW-1:0] A_DATA = BUS_AW'(OFS_DATA);
   localparam logic [BUS_AW-1:0] A_ADDR = BUS_AW'(OFS_ADDR);
   localparam int CFG_PAD = 32 - CFG_DIV_LO - DIV_W;

   logic [FLD_BITS-1:0]  dev_q, prt_q;
   logic [DATA_BITS-1:0] data_q, addr_q;
   logic                 wr_ok;
   fr_kind_e             kind;
   logic [FLD_BITS-1:0]  f_prt, f_dev;
   logic [DATA_BITS-1:0] f_dat;
   logic                 unused_hi;

   assign unused_hi = ^host_wdata[31:DATA_BITS];
   assign wr_ok     = host_wr && !busy;

   always_comb begin
      start = 1'b0;
      kind  = FR_WRITE;
      f_prt = prt_q;
      f_dev = dev_q;
      f_dat = host_wdata[DATA_BITS-1:0];
      if (wr_ok) begin
         unique case (host_addr)
            A_CTRL: begin
               if (host_wdata[CTRL_RD_BIT]) begin
                  start = 1'b1;
                  kind  = FR_READ;
                  f_dev = host_wdata[FLD_BITS-1:0];
                  f_prt = host_wdata[2*FLD_BITS-1:FLD_BITS];
                  f_dat = '1;
               end
            end
            A_DATA: begin
               start = 1'b1;
               kind  = FR_WRITE;
            end
            A_ADDR: begin
               start = cfg_c45;
               kind  = FR_ADDR;
            end
            default: start = 1'b0;
         endcase
      end
   end

   assign start_read = start && (kind == FR_READ);
   assign frame      = make_frame(cfg_c45, kind, f_prt, f_dev, f_dat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_div     <= DIV_W'(DIV_RST);
         cfg_pre_off <= 1'b0;
         cfg_c45     <= 1'b0;
         dev_q       <= '0;
         prt_q       <= '0;
         data_q      <= '0;
         addr_q      <= '0;
      end else if (rd_done) begin
         data_q <= rd_word;
      end else if (wr_ok) begin
         unique case (host_addr)
            A_CFG: begin
               cfg_div     <= host_wdata[CFG_DIV_LO +: DIV_W];
               cfg_pre_off <= host_wdata[CFG_PRE_BIT];
               cfg_c45     <= host_wdata[CFG_C45_BIT];
            end
            A_CTRL: begin
               dev_q <= host_wdata[FLD_BITS-1:0];
               prt_q <= host_wdata[2*FLD_BITS-1:FLD_BITS];
            end
            A_DATA:  data_q <= host_wdata[DATA_BITS-1:0];
            A_ADDR:  addr_q <= host_wdata[DATA_BITS-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      unique case (host_addr)
         A_CFG:   host_rdata = {{CFG_PAD{1'b0}}, cfg_div, cfg_c45, cfg_pre_off,
                                3'b000, rd_err, busy};
         A_CTRL:  host_rdata = {22'd0, prt_q, dev_q};
         A_DATA:  host_rdata = {16'd0, data_q};
         A_ADDR:  host_rdata = {16'd0, addr_q};
         default: host_rdata = 32'd0;
      endcase
   end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV_W   = 9,
   parameter int DIV_RST = 5,
   parameter int BUS_AW  = 4,
   parameter int IN_SYNC = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [BUS_AW-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              mdc,
   output logic              mdio_out,
   output logic              mdio_oe,
   input  logic              mdio_in
);

   if (DIV_W < 3 || DIV_W > 9) begin : g_bad_div_w
      $error("DIV_W must lie in 3..9 to fit configuration bits 15:7");
   end
   if (DIV_RST < 0 || DIV_RST >= (1 << DIV_W)) begin : g_bad_div_rst
      $error("DIV_RST does not fit in DIV_W bits");
   end
   if (BUS_AW < 4) begin : g_bad_aw
      $error("BUS_AW must reach word 15");
   end
   if (IN_SYNC < 0 || IN_SYNC > 4) begin : g_bad_sync
      $error("IN_SYNC must lie in 0..4");
   end

   logic                  busy;
   logic                  fall_stb, rise_stb;
   logic                  start, start_read;
   logic [FRAME_BITS-1:0] frame;
   logic [DIV_W-1:0]      cfg_div;
   logic                  cfg_pre_off, cfg_c45;
   logic                  rd_done, rd_err;
   logic [DATA_BITS-1:0]  rd_word;
   logic                  line_s;

   if (IN_SYNC == 0) begin : g_nosync
      assign line_s = mdio_in;
   end else begin : g_sync
      logic [IN_SYNC-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[IN_SYNC-1:0], mdio_in} >> 0;
      end
      assign line_s = sync_q[IN_SYNC-1];
   end

   mdio_regfile #(
      .DIV_W   (DIV_W),
      .DIV_RST (DIV_RST),
      .BUS_AW  (BUS_AW)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_wr     (host_wr),
      .host_addr   (host_addr),
      .host_wdata  (host_wdata),
      .host_rdata  (host_rdata),
      .busy        (busy),
      .rd_err      (rd_err),
      .rd_done     (rd_done),
      .rd_word     (rd_word),
      .start       (start),
      .start_read  (start_read),
      .frame       (frame),
      .cfg_div     (cfg_div),
      .cfg_pre_off (cfg_pre_off),
      .cfg_c45     (cfg_c45)
   );

   mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div      (cfg_div),
      .mdc      (mdc),
      .fall_stb (fall_stb),
      .rise_stb (rise_stb)
   );

   mdio_frame_eng u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .is_read  (start_read),
      .skip_pre (cfg_pre_off),
      .frame    (frame),
      .fall_stb (fall_stb),
      .rise_stb (rise_stb),
      .line_in  (line_s),
      .busy     (busy),
      .mdio_out (mdio_out),
      .mdio_oe  (mdio_oe),
      .rd_done  (rd_done),
      .rd_err   (rd_err),
      .rd_word  (rd_word)
   );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int DIV_W = 9
)(
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             mdc,
   input logic             mdio_out,
   input logic             mdio_oe,
   input logic             host_wr,
   input logic [DIV_W-1:0] cfg_div,
   input logic             cfg_pre_off,
   input logic             cfg_c45
);

   logic [DIV_W:0] hc_q;
   logic           mdc_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc_q  <= '0;
         mdc_d <= 1'b1;
      end else begin
         mdc_d <= mdc;
         if (!busy || (mdc != mdc_d)) hc_q <= busy ? (DIV_W+1)'(1) : '0;
         else                          hc_q <= hc_q + 1'b1;
      end
   end

   assert_mdc_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> mdc);

   assert_line_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);

   assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (mdc != mdc_d)) |-> (hc_q == ({1'b0, cfg_div} + 1'b1)));

   assert_out_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_out) |-> $fell(mdc));

   assert_oe_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdio_oe) |-> $fell(mdc));

   assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_wr) |=> ($stable(cfg_div) && $stable(cfg_pre_off) && $stable(cfg_c45)));

endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .mdc         (mdc),
   .mdio_out    (mdio_out),
   .mdio_oe     (mdio_oe),
   .host_wr     (host_wr),
   .cfg_div     (cfg_div),
   .cfg_pre_off (cfg_pre_off),
   .cfg_c45     (cfg_c45)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        mdc, mdio_out, mdio_oe, mdio_in;

   always #2 clk = ~clk;

   // PHY model state
   logic        phy_on = 1'b0, phy_rd = 1'b0, phy_pre = 1'b0;
   logic        phy_drv = 1'b0, phy_bit = 1'b1;
   logic [15:0] phy_resp = '0;
   int          fidx = 0;
   logic [63:0] log_bits, log_oe;
   int          nbits = 0;
   logic        mdc_n = 1'b1, ln_d = 1'b1, oe_d = 1'b0;
   int          cyc = 0, last_fall = 0, period = 0;

   int n_cmp = 0, n_bad = 0;
   int cur_div = 5;

   assign mdio_in = mdio_oe ? mdio_out : (phy_drv ? phy_bit : 1'b1);

   mdio_master uut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
      .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
   );

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (mdc && !mdc_n) begin
         log_bits = {log_bits[62:0], ln_d};
         log_oe   = {log_oe[62:0], oe_d};
         nbits    = nbits + 1;
      end
      if (!mdc && mdc_n) begin
         int fp;
         period    = cyc - last_fall;
         last_fall = cyc;
         fp = fidx - (phy_pre ? 0 : 32);
         if (phy_on && phy_rd && fp >= 15 && fp <= 31) begin
            phy_drv = 1'b1;
            phy_bit = (fp == 15) ? 1'b0 : phy_resp[31-fp];
         end else begin
            phy_drv = 1'b0;
         end
         fidx = fidx + 1;
      end
      mdc_n = mdc;
      ln_d  = mdio_in;
      oe_d  = mdio_oe;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      int guard = 0;
      do begin
         rd(4'd12, s);
         guard++;
      end while (s[0] && guard < 40000);
      if (guard >= 40000) chk("R8 watchdog busy", 1, 0);
      repeat (3) @(negedge clk);
   endtask

   function automatic logic [31:0] ref_frame(input bit c45, input int kind,
      input logic [4:0] p, input logic [4:0] d, input logic [15:0] v);
      logic [1:0] st, op;
      st = c45 ? 2'b00 : 2'b01;
      if (kind == 0)      op = 2'b00;
      else if (kind == 1) op = 2'b01;
      else                op = c45 ? 2'b11 : 2'b10;
      return {st, op, p, d, 2'b10, v};
   endfunction

   function automatic logic [31:0] cfg_word(input int dv, input bit c45, input bit pre_off);
      return (32'(dv) << 7) | (32'(c45) << 6) | (32'(pre_off) << 5);
   endfunction

   // kind: 0 address, 1 write, 2 read
   task automatic run_frame(input int kind, input bit c45, input bit pre_off,
      input logic [4:0] p, input logic [4:0] d, input logic [15:0] v, input bit respond);
      logic [31:0] s, r, fr;
      string tg;
      tg = (kind == 2) ? (c45 ? "R6 c45 read" : "R4 c22 read")
         : (kind == 1) ? (c45 ? "R6 c45 write" : "R3 c22 write") : "R5 c45 address";
      wr(4'd12, cfg_word(cur_div, c45, pre_off));
      if (kind != 2) wr(4'd13, {22'd0, p, d});
      phy_on = respond; phy_rd = (kind == 2); phy_pre = pre_off; phy_resp = v;
      phy_drv = 1'b0; fidx = 0; nbits = 0; log_bits = '0; log_oe = '0;
      if (kind == 0)      wr(4'd15, {16'd0, v});
      else if (kind == 1) wr(4'd14, {16'd0, v});
      else                wr(4'd13, 32'h8000 | {22'd0, p, d});
      rd(4'd12, s);
      chk("R8 busy set after launch", s[0], 1);
      wait_idle();
      phy_drv = 1'b0;
      fr = ref_frame(c45, kind, p, d, v);
      chk({"R7 bit count ", tg}, nbits, pre_off ? 32 : 64);
      if (!pre_off) chk({"R7 preamble ", tg}, log_bits[63:32], 32'hFFFF_FFFF);
      if (kind != 2) begin
         chk({tg, " wire bits"}, log_bits[31:0], fr);
         chk({tg, " driven throughout"}, log_oe[31:0], 32'hFFFF_FFFF);
      end else begin
         chk({tg, " header bits"}, log_bits[31:18], fr[31:18]);
         chk({tg, " release pattern"}, log_oe[31:0], 32'hFFFC_0000);
         rd(4'd14, r);
         chk({tg, " data"}, r, respond ? {16'd0, v} : 32'h0000_FFFF);
         rd(4'd12, s);
         chk("R9 error flag", s[1], !respond);
      end
   endtask

   initial begin
      #(200000 * 4);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'h5EED_0A11));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state and map
      rd(4'd12, r); chk("R1 cfg reset", r, 32'h280);
      rd(4'd13, r); chk("R1 ctrl reset", r, 0);
      rd(4'd14, r); chk("R1 data reset", r, 0);
      rd(4'd3,  r); chk("R1 reserved word", r, 0);
      chk("R2 idle mdc", mdc, 1);
      chk("R2 idle release", mdio_oe, 0);

      // directed frames
      cur_div = 5;
      run_frame(1, 0, 0, 5'h03, 5'h11, 16'hA5C3, 1);
      chk("R2 mdc period div5", period, 12);
      run_frame(2, 0, 0, 5'h1F, 5'h02, 16'h3C96, 1);
      run_frame(2, 0, 1, 5'h07, 5'h01, 16'h0000, 0);
      run_frame(2, 0, 1, 5'h07, 5'h01, 16'hFFFE, 1);
      run_frame(0, 1, 0, 5'h10, 5'h1E, 16'h8001, 1);
      run_frame(1, 1, 1, 5'h01, 5'h03, 16'h1234, 1);
      run_frame(2, 1, 0, 5'h0A, 5'h07, 16'hBEEF, 1);
      rd(4'd13, r); chk("R4 read bit not stored", r, {22'd0, 5'h0A, 5'h07});

      // R5: address write in Clause 22 mode only stores
      wr(4'd12, cfg_word(5, 0, 0));
      nbits = 0;
      wr(4'd15, 32'h0000_4321);
      rd(4'd12, r); chk("R5 no busy in c22 address write", r[0], 0);
      repeat (100) @(negedge clk);
      chk("R5 no frame in c22 address write", nbits, 0);
      rd(4'd15, r); chk("R5 address stored", r, 32'h4321);

      // R8: writes while busy are ignored
      wr(4'd12, cfg_word(6, 0, 1));
      wr(4'd13, {22'd0, 5'h05, 5'h06});
      nbits = 0; log_bits = '0; phy_on = 1'b0; phy_pre = 1'b1; fidx = 0;
      wr(4'd14, 32'h0000_CAFE);
      wr(4'd14, 32'h0000_1111);
      wr(4'd13, 32'h0000_03FF);
      wr(4'd12, cfg_word(9, 1, 0));
      wait_idle();
      chk("R8 frame kept first value", log_bits[31:0], ref_frame(0, 1, 5'h05, 5'h06, 16'hCAFE));
      rd(4'd14, r); chk("R8 data unchanged", r, 32'hCAFE);
      rd(4'd13, r); chk("R8 ctrl unchanged", r, {22'd0, 5'h05, 5'h06});
      rd(4'd12, r); chk("R8 cfg unchanged", r, cfg_word(6, 0, 1));

      // R2: largest divisor
      cur_div = 511;
      run_frame(1, 0, 1, 5'h02, 5'h04, 16'h5A5A, 1);
      chk("R2 mdc period div511", period, 1024);
      rd(4'd12, r); chk("R10 no busy after last edge", r[0], 0);

      // random mix
      for (int i = 0; i < 24; i++) begin
         int k; bit c45;
         k   = $urandom_range(0, 2);
         c45 = $urandom_range(0, 1);
         if (k == 0) c45 = 1'b1;
         cur_div = $urandom_range(5, 9);
         run_frame(k, c45, $urandom_range(0, 1), 5'($urandom), 5'($urandom),
                   16'($urandom), $urandom_range(0, 5) != 0);
         chk("R2 mdc period random", period, 2 * (cur_div + 1));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule